// File: doc/BRIEF.md
# Ingress Bus Address Window Translator

This block sits on the inbound request path of an I/O bridge. Each incoming read or write request carries a bus address and a few attributes. The block compares the page number of that address against a small table of programmable windows. Each window covers a whole number of 4 KiB pages and carries its own target base, address-space identifier, port number and ordering mode. The winning window turns the bus page into a virtual target page. A second lookup then resolves that virtual page through the small page-translation table owned by the window's space identifier, which yields a physical page.

The result reaches the output channel as a physical address with exactly one outcome flag set: hit, window miss or translation fault. The output also carries the window's port, the window index and a fence bit. The fence bit tells the downstream logic whether this request must wait for earlier traffic. A configuration port writes windows and page entries. It rejects malformed writes, and a freshly written window stays disabled until it is enabled on purpose. The lookup is a two-stage pipeline that accepts one request per cycle, and it stalls as a whole when the output is not taken.

Top module: `bus_win_xlate`

## Requirements
- R1: After reset, out_valid and cfg_err are low and req_ready is high; every window and every page entry is invalid.
- R2: A window matches when it is enabled and the request page number (address bits [63:12]) lies in [base page, base page + size pages). The low 12 address bits take no part in matching and are copied unchanged to out_addr[11:0] on a hit.
- R3: When several windows match, the lowest-numbered one is used.
- R4: On a hit, virtual page = target page + (request page - base page). That page is looked up among the valid entries of the window's space identifier, and out_addr = {physical page, offset}. out_port and out_win give the window's port and index.
- R5: Each output has exactly one of out_hit, out_miss, out_fault set. With no window, out_miss=1. With a window but no page entry, out_fault=1. In both cases out_addr is 0. out_port and out_win are 0 on a miss.
- R6: A window whose space identifier is all ones (3) never matches, even when the address is in range.
- R7: cfg_err pulses one cycle after a rejected write, and the table is left unchanged. A window write (cfg_op=0) is rejected when the index is 8 or more, the bus base or target base has nonzero low 12 bits, or the size is zero or not a multiple of 4096. Enable (1) and disable (2) are rejected when the index is 8 or more. A page write (3) is rejected when the space is 3 or either address has nonzero low 12 bits.
- R8: A window write stores the new fields and leaves the window disabled. Op 1 enables the window and op 2 disables it. A page write (space=cfg_space, slot=cfg_idx, virtual page from cfg_bus_addr, physical page from cfg_tgt_addr) makes that entry valid.
- R9: A request accepted at a clock edge appears on the output after the following edge. While out_valid is high and out_ready low, the output holds and req_ready is low. Otherwise one request is taken per cycle.
- R10: out_fence = 1 for every read, for every window miss, and for writes whose mode is 1 (strict) or 3. In mode 2 (per-packet), a write gets out_fence = !req_relaxed. In mode 0 (free), a write gets out_fence = 0. out_write echoes req_write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_valid | input | 1 | Configuration write strobe |
| cfg_op | input | 2 | 0 window write, 1 enable, 2 disable, 3 page write |
| cfg_idx | input | 4 | Window index or page slot |
| cfg_space | input | 2 | Space identifier (3 = none) |
| cfg_bus_addr | input | 64 | Window bus base, or virtual address of a page entry |
| cfg_tgt_addr | input | 64 | Window target base, or physical address of a page entry |
| cfg_size | input | 64 | Window size in bytes |
| cfg_port | input | 2 | Window port number |
| cfg_order | input | 2 | Window ordering mode |
| cfg_err | output | 1 | Rejected configuration write |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_addr | input | 64 | Request bus address |
| req_write | input | 1 | 1 write, 0 read |
| req_relaxed | input | 1 | Relaxed-ordering attribute of the request |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Result taken when high with out_valid |
| out_hit | output | 1 | Window and page both found |
| out_miss | output | 1 | No window matched |
| out_fault | output | 1 | Window matched, page not found |
| out_addr | output | 64 | Translated physical address |
| out_win | output | 3 | Matching window index |
| out_port | output | 2 | Port number of the matching window |
| out_write | output | 1 | Echo of req_write |
| out_fence | output | 1 | Request must wait for earlier traffic |

## Verification
The bench probes windows right at their edges: the last page inside, the first page past the end and the page below the base. A design with an off-by-one size compare would hit one page too many or too few. Overlapping windows catch a priority encoder that picks the highest index. Reprogramming an enabled window catches a design that keeps a half-written entry live. A window with the all-ones space catches a design that treats that value as a real space. Rejected writes must leave the old mapping in effect, so a design that stores bad fields would return a different address. Random traffic under random output stalls exposes pipeline slips, where results are dropped, duplicated or paired with the wrong request.

// File: rtl/xlt_pkg.sv
package xlt_pkg;
  localparam int PG_SHIFT = 12;

  typedef enum logic [1:0] {
    OP_WIN_WRITE   = 2'd0,
    OP_WIN_ENABLE  = 2'd1,
    OP_WIN_DISABLE = 2'd2,
    OP_PAGE_WRITE  = 2'd3
  } cfg_op_e;

  typedef enum logic [1:0] {
    ORD_FREE   = 2'd0,
    ORD_STRICT = 2'd1,
    ORD_PKT    = 2'd2,
    ORD_RSVD   = 2'd3
  } ord_e;
endpackage

// File: rtl/xlt_win_table.sv
module xlt_win_table #(
  parameter int NUM_WIN = 8,
  parameter int PN_W    = 52,
  parameter int ID_W    = 2,
  parameter int PORT_W  = 2,
  localparam int WIN_IW = $clog2(NUM_WIN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              en_set,
  input  logic              en_clr,
  input  logic [WIN_IW-1:0] wr_idx,
  input  logic [PN_W-1:0]   wr_base_pn,
  input  logic [PN_W-1:0]   wr_tgt_pn,
  input  logic [PN_W-1:0]   wr_size_pn,
  input  logic [ID_W-1:0]   wr_space,
  input  logic [PORT_W-1:0] wr_port,
  input  logic [1:0]        wr_order,
  input  logic [PN_W-1:0]   lk_pn,
  output logic              lk_hit,
  output logic [WIN_IW-1:0] lk_win,
  output logic [PN_W-1:0]   lk_vpn,
  output logic [ID_W-1:0]   lk_space,
  output logic [PORT_W-1:0] lk_port,
  output logic [1:0]        lk_order
);
  logic [NUM_WIN-1:0] ena_q, ena_d;
  logic [PN_W-1:0]    base_q  [NUM_WIN];
  logic [PN_W-1:0]    tgt_q   [NUM_WIN];
  logic [PN_W-1:0]    size_q  [NUM_WIN];
  logic [ID_W-1:0]    space_q [NUM_WIN];
  logic [PORT_W-1:0]  port_q  [NUM_WIN];
  logic [1:0]         order_q [NUM_WIN];

  always_comb begin
    ena_d = ena_q;
    for (int w = 0; w < NUM_WIN; w++) begin
      if ((wr_en || en_clr) && wr_idx == WIN_IW'(w)) ena_d[w] = 1'b0;
      if (en_set && wr_idx == WIN_IW'(w))            ena_d[w] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ena_q <= '0;
    else        ena_q <= ena_d;
  end

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_entry
    logic ld;
    assign ld = wr_en && (wr_idx == WIN_IW'(w));
    always_ff @(posedge clk) begin
      if (ld) begin
        base_q[w]  <= wr_base_pn;
        tgt_q[w]   <= wr_tgt_pn;
        size_q[w]  <= wr_size_pn;
        space_q[w] <= wr_space;
        port_q[w]  <= wr_port;
        order_q[w] <= wr_order;
      end
    end
  end

  // lowest index wins: scan upward and stop at the first match
  always_comb begin
    logic [PN_W-1:0] off;
    lk_hit   = 1'b0;
    lk_win   = '0;
    lk_vpn   = '0;
    lk_space = '0;
    lk_port  = '0;
    lk_order = xlt_pkg::ORD_STRICT;
    for (int w = 0; w < NUM_WIN; w++) begin
      off = lk_pn - base_q[w];
      if (!lk_hit && ena_q[w] && (space_q[w] != '1) &&
          (lk_pn >= base_q[w]) && (off < size_q[w])) begin
        lk_hit   = 1'b1;
        lk_win   = WIN_IW'(w);
        lk_vpn   = tgt_q[w] + off;
        lk_space = space_q[w];
        lk_port  = port_q[w];
        lk_order = order_q[w];
      end
    end
  end
endmodule

// File: rtl/xlt_page_table.sv
module xlt_page_table #(
  parameter int PN_W      = 52,
  parameter int ID_W      = 2,
  parameter int PG_PER_ID = 16,
  localparam int NUM_ID  = (1 << ID_W) - 1,
  localparam int NUM_ENT = NUM_ID * PG_PER_ID,
  localparam int SLOT_W  = $clog2(PG_PER_ID)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ID_W-1:0]   wr_space,
  input  logic [SLOT_W-1:0] wr_slot,
  input  logic [PN_W-1:0]   wr_vpn,
  input  logic [PN_W-1:0]   wr_ppn,
  input  logic [ID_W-1:0]   lk_space,
  input  logic [PN_W-1:0]   lk_vpn,
  output logic              lk_hit,
  output logic [PN_W-1:0]   lk_ppn
);
  logic [NUM_ENT-1:0] vld_q, vld_d;
  logic [PN_W-1:0]    vpn_q [NUM_ENT];
  logic [PN_W-1:0]    ppn_q [NUM_ENT];
  int                 wr_ent;

  assign wr_ent = int'(wr_space) * PG_PER_ID + int'(wr_slot);

  always_comb begin
    vld_d = vld_q;
    for (int e = 0; e < NUM_ENT; e++)
      if (wr_en && wr_ent == e) vld_d[e] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  for (genvar e = 0; e < NUM_ENT; e++) begin : g_ent
    always_ff @(posedge clk) begin
      if (wr_en && wr_ent == e) begin
        vpn_q[e] <= wr_vpn;
        ppn_q[e] <= wr_ppn;
      end
    end
  end

  always_comb begin
    int sp;
    int e;
    sp     = (int'(lk_space) < NUM_ID) ? int'(lk_space) : 0;
    lk_hit = 1'b0;
    lk_ppn = '0;
    for (int s = 0; s < PG_PER_ID; s++) begin
      e = sp * PG_PER_ID + s;
      if (!lk_hit && (int'(lk_space) < NUM_ID) && vld_q[e] && vpn_q[e] == lk_vpn) begin
        lk_hit = 1'b1;
        lk_ppn = ppn_q[e];
      end
    end
  end
endmodule

// File: rtl/xlt_order_fence.sv
module xlt_order_fence (
  input  logic       is_write,
  input  logic       relaxed,
  input  logic [1:0] mode,
  output logic       fence
);
  import xlt_pkg::*;
  always_comb begin
    if (!is_write) fence = 1'b1;
    else begin
      case (ord_e'(mode))
        ORD_FREE: fence = 1'b0;
        ORD_PKT:  fence = !relaxed;
        default:  fence = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/bus_win_xlate.sv
module bus_win_xlate #(
  parameter int ADDR_W    = 64,
  parameter int NUM_WIN   = 8,
  parameter int ID_W      = 2,
  parameter int PG_PER_ID = 16,
  parameter int PORT_W    = 2,
  localparam int PN_W   = ADDR_W - xlt_pkg::PG_SHIFT,
  localparam int WIN_IW = $clog2(NUM_WIN),
  localparam int SLOT_W = $clog2(PG_PER_ID),
  localparam int IDX_W  = (WIN_IW > SLOT_W) ? WIN_IW : SLOT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_valid,
  input  logic [1:0]        cfg_op,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [ID_W-1:0]   cfg_space,
  input  logic [ADDR_W-1:0] cfg_bus_addr,
  input  logic [ADDR_W-1:0] cfg_tgt_addr,
  input  logic [ADDR_W-1:0] cfg_size,
  input  logic [PORT_W-1:0] cfg_port,
  input  logic [1:0]        cfg_order,
  output logic              cfg_err,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic              req_relaxed,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_hit,
  output logic              out_miss,
  output logic              out_fault,
  output logic [ADDR_W-1:0] out_addr,
  output logic [WIN_IW-1:0] out_win,
  output logic [PORT_W-1:0] out_port,
  output logic              out_write,
  output logic              out_fence
);
  import xlt_pkg::*;
  localparam int OFF_W = PG_SHIFT;

  // reset: asserted asynchronously, released through two flops
  logic rst_meta, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  // configuration decode and checking
  cfg_op_e op;
  logic    bus_al, tgt_al, size_al, win_idx_ok, slot_ok, space_ok, cfg_ok;
  logic    win_wr, win_set, win_clr, pg_wr, cfg_err_d, cfg_err_q;

  always_comb begin
    op         = cfg_op_e'(cfg_op);
    bus_al     = (cfg_bus_addr[OFF_W-1:0] == '0);
    tgt_al     = (cfg_tgt_addr[OFF_W-1:0] == '0);
    size_al    = (cfg_size[OFF_W-1:0] == '0) && (cfg_size != '0);
    win_idx_ok = int'(cfg_idx) < NUM_WIN;
    slot_ok    = int'(cfg_idx) < PG_PER_ID;
    space_ok   = (cfg_space != '1);
    case (op)
      OP_WIN_WRITE:  cfg_ok = win_idx_ok && bus_al && tgt_al && size_al;
      OP_PAGE_WRITE: cfg_ok = slot_ok && space_ok && bus_al && tgt_al;
      default:       cfg_ok = win_idx_ok;
    endcase
    win_wr    = cfg_valid && cfg_ok && (op == OP_WIN_WRITE);
    win_set   = cfg_valid && cfg_ok && (op == OP_WIN_ENABLE);
    win_clr   = cfg_valid && cfg_ok && (op == OP_WIN_DISABLE);
    pg_wr     = cfg_valid && cfg_ok && (op == OP_PAGE_WRITE);
    cfg_err_d = cfg_valid && !cfg_ok;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) cfg_err_q <= 1'b0;
    else             cfg_err_q <= cfg_err_d;
  end
  assign cfg_err = cfg_err_q;

  // stage 1: window compare
  logic              w_hit;
  logic [WIN_IW-1:0] w_win;
  logic [PN_W-1:0]   w_vpn;
  logic [ID_W-1:0]   w_space;
  logic [PORT_W-1:0] w_port;
  logic [1:0]        w_order;

  xlt_win_table #(.NUM_WIN(NUM_WIN), .PN_W(PN_W), .ID_W(ID_W), .PORT_W(PORT_W)) u_win (
    .clk(clk), .rst_n(rst_sync_n),
    .wr_en(win_wr), .en_set(win_set), .en_clr(win_clr),
    .wr_idx(cfg_idx[WIN_IW-1:0]),
    .wr_base_pn(cfg_bus_addr[ADDR_W-1:OFF_W]),
    .wr_tgt_pn(cfg_tgt_addr[ADDR_W-1:OFF_W]),
    .wr_size_pn(cfg_size[ADDR_W-1:OFF_W]),
    .wr_space(cfg_space), .wr_port(cfg_port), .wr_order(cfg_order),
    .lk_pn(req_addr[ADDR_W-1:OFF_W]),
    .lk_hit(w_hit), .lk_win(w_win), .lk_vpn(w_vpn),
    .lk_space(w_space), .lk_port(w_port), .lk_order(w_order)
  );

  logic              advance;
  logic              s1_vld_q, s1_vld_d, s1_ld;
  logic              s1_hit_q, s1_write_q, s1_rel_q;
  logic [WIN_IW-1:0] s1_win_q;
  logic [PN_W-1:0]   s1_vpn_q;
  logic [OFF_W-1:0]  s1_off_q;
  logic [ID_W-1:0]   s1_space_q;
  logic [PORT_W-1:0] s1_port_q;
  logic [1:0]        s1_order_q;

  assign advance   = !out_valid || out_ready;
  assign req_ready = advance;

  always_comb begin
    s1_vld_d = advance ? req_valid : s1_vld_q;
    s1_ld    = advance && req_valid;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) s1_vld_q <= 1'b0;
    else             s1_vld_q <= s1_vld_d;
  end

  always_ff @(posedge clk) begin
    if (s1_ld) begin
      s1_hit_q   <= w_hit;
      s1_win_q   <= w_win;
      s1_vpn_q   <= w_vpn;
      s1_off_q   <= req_addr[OFF_W-1:0];
      s1_space_q <= w_space;
      s1_port_q  <= w_port;
      s1_order_q <= w_order;
      s1_write_q <= req_write;
      s1_rel_q   <= req_relaxed;
    end
  end

  // stage 2: page compare
  logic            p_hit;
  logic [PN_W-1:0] p_ppn;

  xlt_page_table #(.PN_W(PN_W), .ID_W(ID_W), .PG_PER_ID(PG_PER_ID)) u_pg (
    .clk(clk), .rst_n(rst_sync_n),
    .wr_en(pg_wr), .wr_space(cfg_space), .wr_slot(cfg_idx[SLOT_W-1:0]),
    .wr_vpn(cfg_bus_addr[ADDR_W-1:OFF_W]), .wr_ppn(cfg_tgt_addr[ADDR_W-1:OFF_W]),
    .lk_space(s1_space_q), .lk_vpn(s1_vpn_q),
    .lk_hit(p_hit), .lk_ppn(p_ppn)
  );

  logic s2_fence;
  xlt_order_fence u_ord (
    .is_write(s1_write_q), .relaxed(s1_rel_q), .mode(s1_order_q), .fence(s2_fence)
  );

  logic              o_vld_d, o_ld;
  logic              o_hit_d, o_miss_d, o_fault_d;
  logic [ADDR_W-1:0] o_addr_d;
  logic [WIN_IW-1:0] o_win_d;
  logic [PORT_W-1:0] o_port_d;

  always_comb begin
    o_vld_d   = advance ? s1_vld_q : out_valid;
    o_ld      = advance && s1_vld_q;
    o_hit_d   = s1_hit_q && p_hit;
    o_miss_d  = !s1_hit_q;
    o_fault_d = s1_hit_q && !p_hit;
    o_addr_d  = o_hit_d ? {p_ppn, s1_off_q} : '0;
    o_win_d   = s1_hit_q ? s1_win_q : '0;
    o_port_d  = s1_hit_q ? s1_port_q : '0;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) out_valid <= 1'b0;
    else             out_valid <= o_vld_d;
  end

  always_ff @(posedge clk) begin
    if (o_ld) begin
      out_hit   <= o_hit_d;
      out_miss  <= o_miss_d;
      out_fault <= o_fault_d;
      out_addr  <= o_addr_d;
      out_win   <= o_win_d;
      out_port  <= o_port_d;
      out_write <= s1_write_q;
      out_fence <= s2_fence;
    end
  end
endmodule

// File: rtl/bus_win_xlate_chk.sv
module bus_win_xlate_chk #(
  parameter int ADDR_W = 64
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic              cfg_valid,
  input logic              cfg_err,
  input logic              req_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic              out_hit,
  input logic              out_miss,
  input logic              out_fault,
  input logic [ADDR_W-1:0] out_addr,
  input logic              out_write,
  input logic              out_fence
);
  assert_reset_idle_R1: assert property (@(posedge clk)
    !rst_sync_n |-> (!out_valid && !cfg_err));

  assert_one_flag_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    out_valid |-> $onehot({out_hit, out_miss, out_fault}));

  assert_no_addr_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (out_valid && !out_hit) |-> (out_addr == '0));

  assert_err_cause_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cfg_err |-> $past(cfg_valid));

  assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_addr) &&
                                   $stable({out_hit, out_miss, out_fault, out_fence})));

  assert_backpressure_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (out_valid && !out_ready) |-> !req_ready);

  assert_read_fence_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (out_valid && (!out_write || out_miss)) |-> out_fence);
endmodule

bind bus_win_xlate bus_win_xlate_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .cfg_valid(cfg_valid), .cfg_err(cfg_err),
  .req_ready(req_ready), .out_valid(out_valid), .out_ready(out_ready),
  .out_hit(out_hit), .out_miss(out_miss), .out_fault(out_fault),
  .out_addr(out_addr), .out_write(out_write), .out_fence(out_fence)
);

// File: tb/bus_win_xlate_test.sv
module bus_win_xlate_test;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic        hit, miss, fault;
    logic [63:0] addr;
    logic [2:0]  win;
    logic [1:0]  port;
    logic        wr, fence;
  } res_t;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cfg_valid = 0;
  logic [1:0]  cfg_op = 0, cfg_space = 0, cfg_port = 0, cfg_order = 0;
  logic [3:0]  cfg_idx = 0;
  logic [63:0] cfg_bus_addr = 0, cfg_tgt_addr = 0, cfg_size = 0;
  logic        cfg_err;
  logic        req_valid = 0, req_ready, req_write = 0, req_relaxed = 0;
  logic [63:0] req_addr = 0;
  logic        out_valid, out_ready = 1, out_hit, out_miss, out_fault, out_write, out_fence;
  logic [63:0] out_addr;
  logic [2:0]  out_win;
  logic [1:0]  out_port;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // bench-side model of the programmed tables
  bit          m_en  [8];
  logic [51:0] m_base[8], m_size[8], m_tgt[8];
  logic [1:0]  m_sp  [8], m_port[8], m_ord[8];
  bit          p_vld [3][16];
  logic [51:0] p_vpn [3][16], p_ppn[3][16];
  res_t        expq[$];

  bus_win_xlate uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string rq, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  task automatic finish_tb();
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  function automatic res_t model(logic [63:0] a, logic wr, logic rel);
    res_t r;
    logic [51:0] apn, vpn;
    int w;
    apn = a[63:12];
    r = '0;
    r.wr = wr;
    w = -1;
    for (int i = 0; i < 8; i++)
      if (w < 0 && m_en[i] && m_sp[i] != 2'd3 && apn >= m_base[i] && (apn - m_base[i]) < m_size[i])
        w = i;
    if (w < 0) begin
      r.miss = 1; r.fence = 1;
      return r;
    end
    r.win  = 3'(w);
    r.port = m_port[w];
    r.fence = !wr || m_ord[w] == 2'd1 || m_ord[w] == 2'd3 || (m_ord[w] == 2'd2 && !rel);
    vpn = m_tgt[w] + (apn - m_base[w]);
    r.fault = 1;
    for (int k = 0; k < 16; k++)
      if (r.fault && p_vld[m_sp[w]][k] && p_vpn[m_sp[w]][k] == vpn) begin
        r.fault = 0; r.hit = 1;
        r.addr = {p_ppn[m_sp[w]][k], a[11:0]};
      end
    return r;
  endfunction

  task automatic cmp(string rq, res_t e);
    chk(rq, "flags", {61'd0, out_hit, out_miss, out_fault}, {61'd0, e.hit, e.miss, e.fault});
    chk(rq, "addr", out_addr, e.addr);
    chk(rq, "win/port", {59'd0, out_win, out_port}, {59'd0, e.win, e.port});
    chk(rq, "write/fence", {62'd0, out_write, out_fence}, {62'd0, e.wr, e.fence});
  endtask

  task automatic cfg(string rq, logic [1:0] op, logic [3:0] idx, logic [1:0] sp,
                     logic [63:0] bus, logic [63:0] tgt, logic [63:0] sz,
                     logic [1:0] port, logic [1:0] ord);
    bit ok;
    case (op)
      2'd0: ok = idx < 8 && bus[11:0] == 0 && tgt[11:0] == 0 && sz[11:0] == 0 && sz != 0;
      2'd3: ok = sp != 2'd3 && bus[11:0] == 0 && tgt[11:0] == 0;
      default: ok = idx < 8;
    endcase
    @(negedge clk);
    cfg_valid = 1; cfg_op = op; cfg_idx = idx; cfg_space = sp;
    cfg_bus_addr = bus; cfg_tgt_addr = tgt; cfg_size = sz; cfg_port = port; cfg_order = ord;
    @(negedge clk);
    cfg_valid = 0;
    chk(rq, "cfg_err", {63'd0, cfg_err}, {63'd0, !ok});
    if (ok) begin
      case (op)
        2'd0: begin
          m_en[idx] = 0; m_base[idx] = bus[63:12]; m_tgt[idx] = tgt[63:12];
          m_size[idx] = sz[63:12]; m_sp[idx] = sp; m_port[idx] = port; m_ord[idx] = ord;
        end
        2'd1: m_en[idx] = 1;
        2'd2: m_en[idx] = 0;
        default: begin
          p_vld[sp][idx] = 1; p_vpn[sp][idx] = bus[63:12]; p_ppn[sp][idx] = tgt[63:12];
        end
      endcase
    end
  endtask

  // single request through an empty pipe, with latency check
  task automatic xact(string rq, logic [63:0] a, logic wr, logic rel);
    res_t e;
    e = model(a, wr, rel);
    @(negedge clk);
    req_valid = 1; req_addr = a; req_write = wr; req_relaxed = rel; out_ready = 1;
    @(negedge clk);
    req_valid = 0;
    chk("R9", "out_valid one edge after accept", {63'd0, out_valid}, 64'd0);
    @(negedge clk);
    chk("R9", "out_valid two edges after accept", {63'd0, out_valid}, 64'd1);
    cmp(rq, e);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) m_en[i] = 0;
    for (int s = 0; s < 3; s++) for (int k = 0; k < 16; k++) p_vld[s][k] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk("R1", "out_valid after reset", {63'd0, out_valid}, 64'd0);
    chk("R1", "req_ready after reset", {63'd0, req_ready}, 64'd1);
    chk("R1", "cfg_err after reset", {63'd0, cfg_err}, 64'd0);
    xact("R1", 64'h2000_0123, 1, 0);

    // pages and two overlapping windows
    cfg("R8", 2'd3, 0, 0, 64'h1_0000_0000, 64'h77_7000, 0, 0, 0);
    cfg("R8", 2'd3, 1, 0, 64'h1_0000_1000, 64'h55_5000, 0, 0, 0);
    cfg("R8", 2'd3, 0, 1, 64'h1_0000_0000, 64'h99_9000, 0, 0, 0);
    cfg("R8", 2'd0, 0, 0, 64'h2000_0000, 64'h1_0000_0000, 64'h3000, 1, 0);
    xact("R8", 64'h2000_0123, 1, 0);
    cfg("R8", 2'd1, 0, 0, 0, 0, 0, 0, 0);
    cfg("R8", 2'd0, 1, 1, 64'h2000_1000, 64'h1_0000_0000, 64'h1000, 2, 1);
    cfg("R8", 2'd1, 1, 0, 0, 0, 0, 0, 0);

    xact("R2 R4", 64'h2000_0123, 1, 0);
    xact("R3", 64'h2000_1abc, 0, 0);
    xact("R5", 64'h2000_2fff, 1, 0);
    xact("R2", 64'h2000_3000, 1, 0);
    xact("R2", 64'h1fff_ffff, 0, 0);

    // rejected writes leave window 0 as it is
    cfg("R7", 2'd0, 0, 0, 64'h2000_0800, 64'h1_0000_0000, 64'h1000, 0, 0);
    cfg("R7", 2'd0, 0, 0, 64'h2000_0000, 64'h1_0000_0010, 64'h1000, 0, 0);
    cfg("R7", 2'd0, 0, 0, 64'h2000_0000, 64'h1_0000_0000, 64'h1800, 0, 0);
    cfg("R7", 2'd0, 0, 0, 64'h2000_0000, 64'h1_0000_0000, 64'h0, 0, 0);
    cfg("R7", 2'd0, 9, 0, 64'h2000_0000, 64'h1_0000_0000, 64'h1000, 0, 0);
    cfg("R7", 2'd1, 12, 0, 0, 0, 0, 0, 0);
    cfg("R7", 2'd3, 2, 3, 64'h1_0000_0000, 64'h12_3000, 0, 0, 0);
    cfg("R7", 2'd3, 2, 0, 64'h1_0000_0004, 64'h12_3000, 0, 0, 0);
    xact("R7", 64'h2000_1abc, 1, 0);

    cfg("R8", 2'd2, 0, 0, 0, 0, 0, 0, 0);
    xact("R8 R3", 64'h2000_1abc, 1, 0);

    cfg("R6", 2'd0, 2, 3, 64'h3000_0000, 64'h1_0000_0000, 64'h1000, 0, 0);
    cfg("R6", 2'd1, 2, 0, 0, 0, 0, 0, 0);
    xact("R6", 64'h3000_0010, 1, 0);

    for (int m = 0; m < 4; m++) begin
      cfg("R10", 2'd0, 3, 0, 64'h4000_0000, 64'h1_0000_0000, 64'h1000, 3, 2'(m));
      cfg("R10", 2'd1, 3, 0, 0, 0, 0, 0, 0);
      xact("R10", 64'h4000_0040, 1, 1);
      xact("R10", 64'h4000_0040, 1, 0);
      xact("R10", 64'h4000_0040, 0, 1);
    end

    // random phase: reprogram everything, then stream with stalls
    void'($urandom(32'h5eed_1234));
    for (int s = 0; s < 3; s++)
      for (int k = 0; k < 14; k++)
        cfg("R8", 2'd3, 4'(k), 2'(s), {12'd0, 20'h40000 + 20'(k), 32'd0} >> 20,
            {32'd0, 20'($urandom), 12'd0}, 0, 0, 0);
    for (int w = 0; w < 8; w++) begin
      logic [51:0] bpn;
      bpn = (w == 7) ? 52'h10600 : 52'h10000 + 52'(w) * 52'h100;
      cfg("R8", 2'd0, 4'(w), 2'($urandom % 4), {bpn, 12'd0},
          {52'h40000 + 52'($urandom % 11), 12'd0}, {52'(1 + $urandom % 8), 12'd0},
          2'($urandom), 2'($urandom));
      if ($urandom % 8 != 0) cfg("R8", 2'd1, 4'(w), 0, 0, 0, 0, 0, 0);
    end
    begin
      bit pend;
      pend = 0;
      for (int c = 0; c < 4000; c++) begin
        @(negedge clk);
        if (!pend) begin
          req_valid = ($urandom % 4) != 0;
          if ($urandom % 16 == 0) req_addr = {$urandom, $urandom};
          else req_addr = {52'h10000 + 52'($urandom % 8) * 52'h100 + 52'($urandom % 11) - 52'd1,
                           12'($urandom)};
          req_write = 1'($urandom); req_relaxed = 1'($urandom);
        end
        out_ready = (c > 3990) || ($urandom % 4 != 0);
        if (c > 3990) req_valid = 0;
        #1;
        if (out_valid && out_ready) begin
          if (expq.size() == 0) chk("R9", "unexpected output", 64'd1, 64'd0);
          else cmp("R4 R9", expq.pop_front());
        end
        if (req_valid && req_ready) begin
          expq.push_back(model(req_addr, req_write, req_relaxed));
          pend = 0;
        end else pend = req_valid;
      end
    end
    chk("R9", "outputs left pending", 64'(expq.size()), 64'd0);
    done = 1;
    finish_tb();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_tb();
    end
  end
endmodule